// File: doc/BRIEF.md
# Transmit Frame Assembler

The assembler gathers an outgoing network frame that a host writes as 32-bit words into a 2048-byte buffer, then decides when that frame leaves. The first word written into an empty buffer is a header: its low half gives the payload length, and its high half already holds the first two bytes of the frame. The length is checked against a limit. After each accepted data word the block tests two conditions. The first is a programmable fill threshold. The second is whether enough bytes have arrived to hold the whole frame. When both hold, the block starts sending on its own. A host request pulse forces a send at any time.

The frame goes out one byte per handshake on a valid/ready byte port, and the final byte carries a last flag. Frames shorter than the minimum can be padded with zero bytes. Any check bytes the host placed in the buffer are never sent. When the final byte has been taken, the buffer empties and a one-cycle done pulse appears. A rejected length header gives a one-cycle error pulse. Acknowledging that error flushes the buffer.

Top module: `tx_frame_asm`

## Requirements
- R1: When the buffer is empty, a data write whose low 16 bits exceed 2032 stores nothing and raises `err_pulse` in the next cycle. A header of exactly 2032 is accepted.
- R2: An accepted data word is stored as four bytes, bits [7:0] first. It is stored only if at least 4 of the 2048 bytes are free; otherwise it is dropped.
- R3: A frame is complete when the stored byte count is at least payload length + 16, plus 4 more when `ctl_crc_auto` is 0. That sum is capped at 2048.
- R4: The threshold is met when `thr_value` is below 63 and the byte count is at least 32*thr+4. A threshold of 63 never allows an automatic send.
- R5: After an accepted data write, the send starts if both the threshold and the completion conditions hold. A `send_req` pulse while idle starts a send unconditionally. `busy` is high in the cycle after the starting edge.
- R6: The byte stream holds payload length + 14 bytes, capped at 2046, taken from buffer byte 2 onward. `tx_last` is high on the final byte only.
- R7: With `ctl_pad` set and fewer than 60 bytes to send, the frame is extended with zero bytes to exactly 60. Padding zeroes every byte from payload length + 14 onward, even if the buffer holds data there.
- R8: When the final byte is accepted, `busy` falls, the buffer count returns to 0, and `done_pulse` is high for exactly one cycle.
- R9: `err_ack` empties the buffer, so the next data write is treated as a header.
- R10: While `busy` is high, data writes and send requests are ignored. A byte that is offered but not accepted holds its value, and its last flag, until it is taken.
- R11: After reset the threshold is 63, padding is off, automatic check bytes are off, the buffer is empty and no byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Data word write strobe |
| data_word | input | 32 | Data word; header when the buffer is empty |
| ctl_wr | input | 1 | Load the control bits |
| ctl_pad | input | 1 | Pad short frames to 60 bytes |
| ctl_crc_auto | input | 1 | Check bytes appended on the line, none in the buffer |
| thr_wr | input | 1 | Load the threshold |
| thr_value | input | 6 | Threshold value; 63 disables automatic send |
| send_req | input | 1 | Force a send |
| err_ack | input | 1 | Acknowledge the length error and flush the buffer |
| busy | output | 1 | Frame being streamed; writes ignored |
| err_pulse | output | 1 | One-cycle pulse on a rejected header |
| done_pulse | output | 1 | One-cycle pulse after the last byte is taken |
| tx_valid | output | 1 | Byte offered |
| tx_byte | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
Frames are built with several combinations of payload length, threshold and control bits. A send whose trigger lands one word late or one word early shows up as a wrong `busy` value right after the deciding write. The sets that differ only in the check-byte bit, or only in the threshold, separate the completion rule from the threshold rule. Short frames with stale data past the end, and a frame just above 60 bytes, separate zero padding from plain streaming. Frames at the 2032-byte limit test both the 2048 cap on the completion sum and the word dropped when the buffer is full. A rejected header followed by a valid frame, and a flush in the middle of a frame, show that neither leaves bytes behind. Backpressure with a toggling ready checks that offered bytes stay stable.

// File: rtl/tx_asm_pkg.sv
package tx_asm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHOW  = 2'd2
  } stream_st_t;

  localparam int LEN_FIELD_BYTES = 2;
  localparam int MAC_HDR_BYTES   = 14;
  localparam int CHECK_BYTES     = 4;
endpackage

// File: rtl/tx_word_ram.sv
module tx_word_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tx_send_rules.sv
module tx_send_rules #(
  parameter int FIFO_BYTES = 2048,
  parameter int MIN_FRAME  = 60,
  parameter int THR_W      = 6,
  parameter int CNT_W      = 12
) (
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic [15:0]      pay_len,
  input  logic [THR_W-1:0] thr,
  input  logic             crc_auto,
  input  logic             pad_en,
  output logic             thr_hit,
  output logic             complete,
  output logic [CNT_W-1:0] send_len,
  output logic [CNT_W-1:0] data_len
);
  import tx_asm_pkg::*;

  localparam logic [17:0] FIFO_L   = 18'(FIFO_BYTES);
  localparam logic [17:0] SEND_MAX = 18'(FIFO_BYTES - LEN_FIELD_BYTES);
  localparam logic [17:0] MIN_L    = 18'(MIN_FRAME);
  localparam logic [17:0] NEED_ADD = 18'(LEN_FIELD_BYTES + MAC_HDR_BYTES);
  localparam logic [17:0] CHK_L    = 18'(CHECK_BYTES);
  localparam logic [17:0] HDR_L    = 18'(MAC_HDR_BYTES);

  logic [17:0] fill_x, need_raw, need, thr_bytes, raw_len, cap_len, pad_len;

  always_comb begin
    fill_x    = 18'(fill_cnt);
    need_raw  = 18'(pay_len) + NEED_ADD + (crc_auto ? 18'd0 : CHK_L);
    need      = (need_raw > FIFO_L) ? FIFO_L : need_raw;
    complete  = (fill_x >= need);
    thr_bytes = 18'({thr, 5'b00000}) + 18'd4;
    thr_hit   = (thr != {THR_W{1'b1}}) && (fill_x >= thr_bytes);
    raw_len   = 18'(pay_len) + HDR_L;
    cap_len   = (raw_len > SEND_MAX) ? SEND_MAX : raw_len;
    pad_len   = (pad_en && (cap_len < MIN_L)) ? MIN_L : cap_len;
    data_len  = CNT_W'(cap_len);
    send_len  = CNT_W'(pad_len);
  end
endmodule

// File: rtl/tx_byte_streamer.sv
module tx_byte_streamer #(
  parameter int CNT_W = 12,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] send_len,
  input  logic [CNT_W-1:0] data_len,
  input  logic [31:0]      rd_word,
  input  logic             tx_ready,
  output logic [AW-1:0]    rd_addr,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             tx_last,
  output logic             busy,
  output logic             done_pulse
);
  import tx_asm_pkg::*;

  stream_st_t       st;
  logic [CNT_W-1:0] idx, len_q, dlen_q;
  logic [1:0]       lane_q;
  logic             zero_q, done_q, at_end;
  logic [AW+1:0]    pos;

  assign pos     = (AW+2)'(idx) + (AW+2)'(LEN_FIELD_BYTES);
  assign rd_addr = pos[AW+1:2];
  assign at_end  = (idx == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      idx    <= '0;
      len_q  <= '0;
      dlen_q <= '0;
      lane_q <= '0;
      zero_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          idx    <= '0;
          len_q  <= send_len;
          dlen_q <= data_len;
          st     <= ST_FETCH;
        end
        ST_FETCH: begin
          lane_q <= pos[1:0];
          zero_q <= (idx >= dlen_q);
          st     <= ST_SHOW;
        end
        ST_SHOW: if (tx_ready) begin
          if (at_end) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (lane_q)
      2'd0:    tx_byte = rd_word[7:0];
      2'd1:    tx_byte = rd_word[15:8];
      2'd2:    tx_byte = rd_word[23:16];
      default: tx_byte = rd_word[31:24];
    endcase
    if (zero_q) tx_byte = 8'h00;
  end

  assign tx_valid   = (st == ST_SHOW);
  assign tx_last    = (st == ST_SHOW) && at_end;
  assign busy       = (st != ST_IDLE);
  assign done_pulse = done_q;
endmodule

// File: rtl/tx_frame_asm.sv
module tx_frame_asm #(
  parameter int FIFO_BYTES  = 2048,
  parameter int MAX_PAYLOAD = 2032,
  parameter int MIN_FRAME   = 60,
  parameter int THR_W       = 6,
  localparam int CNT_W      = $clog2(FIFO_BYTES + 1),
  localparam int WORDS      = FIFO_BYTES / 4,
  localparam int AW         = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_wr,
  input  logic [31:0]      data_word,
  input  logic             ctl_wr,
  input  logic             ctl_pad,
  input  logic             ctl_crc_auto,
  input  logic             thr_wr,
  input  logic [THR_W-1:0] thr_value,
  input  logic             send_req,
  input  logic             err_ack,
  output logic             busy,
  output logic             err_pulse,
  output logic             done_pulse,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             tx_last,
  input  logic             tx_ready
);
  localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(FIFO_BYTES - 4);
  localparam logic [15:0]      PAY_LIMIT  = 16'(MAX_PAYLOAD);

  logic [CNT_W-1:0] fill_cnt, cnt_after, send_len, data_len;
  logic [15:0]      len_q, len_eff;
  logic [THR_W-1:0] thr_q;
  logic             pad_q, crc_q, err_q;
  logic             wr_ok, hdr_now, hdr_bad, store, thr_hit, complete;
  logic             start, frame_end;
  logic [AW-1:0]    rd_addr;
  logic [31:0]      rd_word;

  assign wr_ok     = data_wr && !busy && !err_ack;
  assign hdr_now   = wr_ok && (fill_cnt == '0);
  assign hdr_bad   = hdr_now && (data_word[15:0] > PAY_LIMIT);
  assign store     = wr_ok && !hdr_bad && (fill_cnt <= ROOM_LIMIT);
  assign cnt_after = store ? fill_cnt + CNT_W'(4) : fill_cnt;
  assign len_eff   = hdr_now ? data_word[15:0] : len_q;
  assign start     = (wr_ok && !hdr_bad && thr_hit && complete) || (send_req && !busy);
  assign frame_end = tx_valid && tx_ready && tx_last;

  tx_send_rules #(
    .FIFO_BYTES(FIFO_BYTES), .MIN_FRAME(MIN_FRAME), .THR_W(THR_W), .CNT_W(CNT_W)
  ) u_rules (
    .fill_cnt (cnt_after),
    .pay_len  (len_eff),
    .thr      (thr_q),
    .crc_auto (crc_q),
    .pad_en   (pad_q),
    .thr_hit  (thr_hit),
    .complete (complete),
    .send_len (send_len),
    .data_len (data_len)
  );

  tx_word_ram #(.DEPTH(WORDS), .WIDTH(32)) u_ram (
    .clk   (clk),
    .we    (store),
    .waddr (fill_cnt[AW+1:2]),
    .wdata (data_word),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  tx_byte_streamer #(.CNT_W(CNT_W), .AW(AW)) u_stream (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .send_len   (send_len),
    .data_len   (data_len),
    .rd_word    (rd_word),
    .tx_ready   (tx_ready),
    .rd_addr    (rd_addr),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .tx_last    (tx_last),
    .busy       (busy),
    .done_pulse (done_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
      len_q    <= '0;
      thr_q    <= {THR_W{1'b1}};
      pad_q    <= 1'b0;
      crc_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= hdr_bad;
      if (ctl_wr) begin
        pad_q <= ctl_pad;
        crc_q <= ctl_crc_auto;
      end
      if (thr_wr) thr_q <= thr_value;
      if (hdr_now && !hdr_bad) len_q <= data_word[15:0];
      if (err_ack || frame_end) fill_cnt <= '0;
      else if (store)           fill_cnt <= cnt_after;
    end
  end

  assign err_pulse = err_q;
endmodule

// File: rtl/tx_frame_asm_checker.sv
module tx_frame_asm_checker #(
  parameter int FIFO_BYTES = 2048,
  parameter int CNT_W      = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             err_pulse,
  input logic             done_pulse,
  input logic             err_ack,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_last,
  input logic [7:0]       tx_byte,
  input logic [CNT_W-1:0] fill_cnt
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(FIFO_BYTES);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CAP);

  p_reject_empty_r1: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> fill_cnt == '0);

  p_last_done_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> (done_pulse && !busy));

  p_done_empty_r8: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (fill_cnt == '0 && !busy));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  p_hold_byte_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)));

  p_valid_busy_r10: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  p_frozen_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !err_ack) |=> ($stable(fill_cnt) || fill_cnt == '0));
endmodule

bind tx_frame_asm tx_frame_asm_checker #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .err_pulse  (err_pulse),
  .done_pulse (done_pulse),
  .err_ack    (err_ack),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_last    (tx_last),
  .tx_byte    (tx_byte),
  .fill_cnt   (fill_cnt)
);

// File: tb/tx_frame_asm_tb_top.sv
`timescale 1ns/1ps
module tx_frame_asm_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        data_wr = 1'b0;
  logic [31:0] data_word = '0;
  logic        ctl_wr = 1'b0, ctl_pad = 1'b0, ctl_crc_auto = 1'b0;
  logic        thr_wr = 1'b0;
  logic [5:0]  thr_value = '0;
  logic        send_req = 1'b0, err_ack = 1'b0;
  logic        tx_ready = 1'b1;
  logic        busy, err_pulse, done_pulse, tx_valid, tx_last;
  logic [7:0]  tx_byte;

  always #2 clk = ~clk;

  tx_frame_asm dut_i (
    .clk(clk), .rst(rst), .data_wr(data_wr), .data_word(data_word),
    .ctl_wr(ctl_wr), .ctl_pad(ctl_pad), .ctl_crc_auto(ctl_crc_auto),
    .thr_wr(thr_wr), .thr_value(thr_value), .send_req(send_req), .err_ack(err_ack),
    .busy(busy), .err_pulse(err_pulse), .done_pulse(done_pulse),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  int n_chk = 0, n_fail = 0;
  int exp_done = 0, got_done = 0;
  int bcnt = 0, blen = 0, gen_k = 0, rdy_mode = 0;
  bit pad_m = 1'b0, finished = 1'b0;
  logic [7:0] bfifo [0:2047];
  logic [8:0] exp_q [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: scoreboard pop and hold check
  initial begin
    bit stalled = 1'b0;
    logic [7:0] held_b = '0;
    logic held_l = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (done_pulse) got_done++;
      if (stalled) begin
        check(tx_valid && tx_byte == held_b && tx_last == held_l, "R10", "held byte",
              int'(tx_byte), int'(held_b));
      end
      stalled = tx_valid && !tx_ready;
      held_b = tx_byte;
      held_l = tx_last;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10", "unexpected byte", int'(tx_byte), -1);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check(tx_byte == e[7:0], "R6", "byte value", int'(tx_byte), int'(e[7:0]));
          check(tx_last == e[8], "R6", "last flag", int'(tx_last), int'(e[8]));
        end
      end
    end
  end

  // sink ready pattern
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      tx_ready = (rdy_mode == 0) ? 1'b1 : (c % 3 != 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] next_word();
    gen_k++;
    return (32'(gen_k) * 32'h9E3779B1) ^ 32'hC3A50F1E;
  endfunction

  task automatic model_word(input logic [31:0] w);
    if (bcnt == 0 && w[15:0] > 16'd2032) return;
    if (bcnt == 0) blen = int'(w[15:0]);
    if (bcnt <= 2044) begin
      for (int b = 0; b < 4; b++) bfifo[bcnt + b] = w[8*b +: 8];
      bcnt += 4;
    end
  endtask

  task automatic drive_word(input logic [31:0] w);
    @(negedge clk); data_wr = 1'b1; data_word = w;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic put(input logic [31:0] w);
    model_word(w); drive_word(w);
  endtask

  task automatic put_hdr(input int len);
    logic [31:0] w;
    w = next_word();
    put({w[31:16], 16'(len)});
  endtask

  task automatic put_n(input int n);
    for (int i = 0; i < n; i++) put(next_word());
  endtask

  task automatic set_ctl(input bit pad, input bit crc);
    @(negedge clk); ctl_wr = 1'b1; ctl_pad = pad; ctl_crc_auto = crc; pad_m = pad;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic set_thr(input int v);
    @(negedge clk); thr_wr = 1'b1; thr_value = 6'(v);
    @(negedge clk); thr_wr = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); send_req = 1'b1;
    @(negedge clk); send_req = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); err_ack = 1'b1;
    @(negedge clk); err_ack = 1'b0;
    bcnt = 0;
  endtask

  task automatic push_expect();
    int l, tot;
    l = blen + 14;
    if (l > 2046) l = 2046;
    tot = (pad_m && l < 60) ? 60 : l;
    for (int i = 0; i < tot; i++)
      exp_q.push_back({(i == tot - 1), (i < l) ? bfifo[2 + i] : 8'h00});
    exp_done++;
    bcnt = 0;
  endtask

  task automatic trigger_word(input string req);
    logic [31:0] w;
    w = next_word();
    model_word(w);
    push_expect();
    drive_word(w);
    check(busy == 1'b1, req, "send started after deciding write", int'(busy), 1);
  endtask

  task automatic idle_check(input string req, input string what);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && tx_valid == 1'b0, req, what, int'(busy), 0);
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (!busy && exp_q.size() == 0) break;
    end
    @(negedge clk); #2;
    check(exp_q.size() == 0, req, "bytes left in scoreboard", exp_q.size(), 0);
    check(got_done == exp_done, "R8", "done pulse count", got_done, exp_done);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(busy == 1'b0, "R11", "busy after reset", int'(busy), 0);
    check(tx_valid == 1'b0, "R11", "valid after reset", int'(tx_valid), 0);
    check(err_pulse == 1'b0 && done_pulse == 1'b0, "R11", "pulses after reset",
          int'(err_pulse) + int'(done_pulse), 0);

    // R4 threshold 63 blocks auto send; R5 forced send; R11 defaults (no pad, check bytes in buffer)
    put_hdr(4); put_n(5);
    idle_check("R4", "threshold 63 must not auto send");
    push_expect();
    pulse_req();
    check(busy == 1'b1, "R5", "forced send starts", int'(busy), 1);
    wait_done("R11");

    // R3/R5 auto send, check bytes automatic, with backpressure (R10)
    set_thr(0); set_ctl(1'b0, 1'b1); rdy_mode = 1;
    put_hdr(20); put_n(7);
    idle_check("R3", "incomplete frame of 32 bytes");
    trigger_word("R3");
    wait_done("R6");

    // R3 check bytes held in buffer: 4 more bytes needed
    set_ctl(1'b0, 1'b0);
    put_hdr(20); put_n(8);
    idle_check("R3", "36 bytes without auto check bytes");
    trigger_word("R3");
    wait_done("R6");

    // R7 padding of short frame with stale data beyond end
    set_ctl(1'b1, 1'b1);
    put_hdr(10); put_n(5);
    idle_check("R7", "short frame not complete yet");
    trigger_word("R7");
    wait_done("R7");
    // R7 padding irrelevant above 60
    put_hdr(50); put_n(15);
    trigger_word("R7");
    wait_done("R7");
    rdy_mode = 0;

    // R4 threshold 2 needs 68 bytes
    set_ctl(1'b0, 1'b1); set_thr(2);
    put_hdr(20); put_n(15);
    idle_check("R4", "complete but below threshold");
    trigger_word("R4");
    wait_done("R4");

    // R1 rejected header, then clean frame
    set_thr(0);
    drive_word(32'h1234_07F1);
    check(err_pulse == 1'b1, "R1", "error pulse on 2033", int'(err_pulse), 1);
    idle_check("R1", "rejected header starts nothing");
    put_hdr(4); put_n(3);
    trigger_word("R1");
    wait_done("R1");

    // R9 flush by error acknowledge
    put_hdr(40); put_n(1);
    pulse_ack();
    put_hdr(4); put_n(3);
    trigger_word("R9");
    wait_done("R9");

    // R10 writes and requests ignored while busy
    rdy_mode = 1;
    put_hdr(20); put_n(7);
    trigger_word("R10");
    repeat (6) @(negedge clk);
    data_wr = 1'b1; data_word = 32'h0000_0004; send_req = 1'b1;
    @(negedge clk);
    data_wr = 1'b0; send_req = 1'b0;
    wait_done("R10");
    repeat (100) @(negedge clk);
    check(busy == 1'b0 && tx_valid == 1'b0, "R10", "no extra frame", int'(busy), 0);
    rdy_mode = 0;

    // R2 full buffer drops a word; R1 accepts 2032
    set_ctl(1'b0, 1'b0); set_thr(63);
    put_hdr(2032); put_n(512);
    check(err_pulse == 1'b0, "R1", "2032 accepted", int'(err_pulse), 0);
    idle_check("R2", "full buffer without threshold");
    push_expect();
    pulse_req();
    wait_done("R2");

    // R3 cap of completion sum at 2048
    set_thr(0);
    put_hdr(2032); put_n(510);
    idle_check("R3", "511 words below cap");
    trigger_word("R3");
    wait_done("R3");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule